// File: doc/BRIEF.md
# Four-Way Set-Associative Cache

This block sits between a processor request port and an external word-wide memory port. It keeps four ways of 32-byte lines. Each line is eight 32-bit words and has a tag, a valid bit and two dirty bits, one for each four-word half. A request checks all four ways at once. A read that hits returns its word in the same cycle as the request. A cacheable read miss stalls the processor while the block fetches the whole line into the way named by the `victim_way` input. Before that fetch, any dirty halves of the outgoing line are written back. The processor then gets its word from the new line.

Writes never allocate. A write hit updates the stored word. In a write-back region it marks the touched half dirty. In a write-through region it forwards the write to the write-buffer port instead. A write miss goes to the write-buffer port when it is bufferable, and to external memory as a single word otherwise. A non-cacheable read miss is a single-word memory read. When the processor flags an access as sequential and it falls in the same line as the previous hit, the block reuses that hit's way and skips the tag compare. The number of sets is a parameter, `SET_BITS`. Each step up doubles the capacity and moves one address bit from the tag into the index.

The controller has four states:
- `ST_LOOKUP`: idle and compare.
- `ST_EVICT`: write back dirty halves.
- `ST_FILL`: fetch eight words.
- `ST_SINGLE`: one uncached memory word.

The controller has these transitions:
- LOOKUP→EVICT: a cacheable read miss whose victim is valid and dirty.
- LOOKUP→FILL: a cacheable read miss whose victim is clean or invalid.
- LOOKUP→SINGLE: a non-cacheable read miss, or a non-bufferable write miss.
- EVICT→FILL: after the last dirty half has been written.
- FILL→LOOKUP: after word 7 has been accepted.
- SINGLE→LOOKUP: when memory acknowledges the word.

Top module: `four_way_cache`

## Requirements
- R1: The byte offset is address bits [4:0] and the word number is bits [4:2]. The set index is bits [5+SET_BITS-1:5] and the tag is every bit above it. With the default SET_BITS=5 the index is [9:5] and the tag is [31:10], so lines with the same index and different tags can be held in different ways at once.
- R2: A read hit asserts `cpu_ready` in the cycle the request is presented, returns the stored word, and issues no memory beat.
- R3: Reset invalidates every line, so the first read of any address misses. At most one way reports a hit.
- R4: A cacheable read miss fetches eight words with `mem_we`=0, at the line base and then in ascending word order. `cpu_ready` stays low until the fill is done. The read then returns the requested word from the filled line.
- R5: A fill writes into the way given by `victim_way` in the cycle the miss is detected, and replaces the line that was held there.
- R6: A write hit (`cpu_we`=1) replaces the addressed word and completes in its request cycle, with no memory beat.
- R7: A write hit with `cpu_writeback`=1 marks dirty the half (address bit 4) it touches, and makes no write-buffer push. A write hit with `cpu_writeback`=0 leaves dirty state untouched and pulses `wbuf_push` with the address and data.
- R8: A write miss with `cpu_bufferable`=1 pulses `wbuf_push` and completes in its request cycle. It issues no memory beat and does not allocate.
- R9: A write miss with `cpu_bufferable`=0 performs exactly one memory write of that word, then completes, and does not allocate.
- R10: A read miss with `cpu_cacheable`=0 performs exactly one memory read of that word, returns it, and does not allocate.
- R11: Before a fill, each dirty half of a valid victim is written back as four ascending word writes at the victim's old address. Clean halves are skipped, and a fully clean victim causes no write.
- R12: A request with `cpu_seq`=1 to the same line as the previous hit reuses that way and still returns the correct word in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Request valid, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_seq | input | 1 | Request follows the previous one in the same line |
| cpu_addr | input | 32 | Byte address, word aligned |
| cpu_wdata | input | 32 | Write data |
| cpu_cacheable | input | 1 | Read misses may allocate |
| cpu_bufferable | input | 1 | Write misses may go to the write buffer |
| cpu_writeback | input | 1 | Write hits mark dirty instead of writing through |
| victim_way | input | 2 | Way to replace on a fill |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` |
| mem_req | output | 1 | Memory beat requested |
| mem_we | output | 1 | Memory beat is a write |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Current memory beat accepted |
| wbuf_push | output | 1 | Write-buffer entry valid this cycle |
| wbuf_addr | output | 32 | Write-buffer address |
| wbuf_data | output | 32 | Write-buffer data |

## Verification
The bench fills several lines with the same index and different tags, then moves the victim selection among them. A block that ignored `victim_way` or the tag bits would hit where it should miss, or miss where it should hit. It dirties the upper half of one line and both halves of another before evicting each, then checks the memory beat log. A block that wrote back whole lines, skipped dirty halves, or used the new line's address would show the wrong count, order or address. Write misses of both kinds and uncached reads are each followed by a read of the same line. A design that allocated on them would answer without memory beats. Sequential reads inside a hit line check that reusing the way still returns each word.

// File: rtl/cache_pkg.sv
package cache_pkg;
    localparam int WAYS    = 4;
    localparam int WAY_W   = 2;
    localparam int WORDS   = 8;
    localparam int WORD_SW = 3;
    localparam int OFF_W   = 5;
    localparam int ADDR_W  = 32;
    localparam int DATA_W  = 32;

    typedef enum logic [1:0] {
        ST_LOOKUP,
        ST_EVICT,
        ST_FILL,
        ST_SINGLE
    } cache_state_t;
endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store
    import cache_pkg::*;
#(
    parameter int SET_BITS = 5,
    parameter int TAG_W    = 22
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [SET_BITS-1:0]       index,
    input  logic [TAG_W-1:0]          lk_tag,
    output logic [WAYS-1:0]           hit_vec,
    input  logic [WAY_W-1:0]          vic_sel,
    output logic                      vic_valid,
    output logic [1:0]                vic_dirty,
    output logic [TAG_W-1:0]          vic_tag,
    input  logic                      alloc_en,
    input  logic [WAY_W-1:0]          alloc_way,
    input  logic                      dirty_en,
    input  logic [WAY_W-1:0]          dirty_way,
    input  logic                      dirty_half
);
    localparam int SETS = 1 << SET_BITS;

    logic [WAYS-1:0]                way_valid;
    logic [WAYS-1:0][1:0]           way_dirty;
    logic [WAYS-1:0][TAG_W-1:0]     way_tag;
    logic [WAYS-1:0][SETS-1:0]      valid_map;

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            logic [TAG_W-1:0] tags [SETS];
            logic [SETS-1:0]  vld;
            logic [SETS-1:0]  dlo;
            logic [SETS-1:0]  dhi;

            always_ff @(posedge clk) begin
                if (alloc_en && alloc_way == WAY_W'(w)) tags[index] <= lk_tag;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld <= '0;
                    dlo <= '0;
                    dhi <= '0;
                end else begin
                    if (alloc_en && alloc_way == WAY_W'(w)) begin
                        vld[index] <= 1'b1;
                        dlo[index] <= 1'b0;
                        dhi[index] <= 1'b0;
                    end
                    if (dirty_en && dirty_way == WAY_W'(w)) begin
                        if (dirty_half) dhi[index] <= 1'b1;
                        else            dlo[index] <= 1'b1;
                    end
                end
            end

            assign way_valid[w] = vld[index];
            assign way_dirty[w] = {dhi[index], dlo[index]};
            assign way_tag[w]   = tags[index];
            assign hit_vec[w]   = vld[index] && (tags[index] == lk_tag);
            assign valid_map[w] = vld;
        end
    endgenerate

    assign vic_valid = way_valid[vic_sel];
    assign vic_dirty = way_dirty[vic_sel];
    assign vic_tag   = way_tag[vic_sel];

    assert_one_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    assert_alloc_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |=> valid_map[$past(alloc_way)][$past(index)]);
endmodule

// File: rtl/cache_data_store.sv
module cache_data_store
    import cache_pkg::*;
#(
    parameter int SET_BITS = 5
) (
    input  logic                        clk,
    input  logic [SET_BITS-1:0]         index,
    input  logic [WORD_SW-1:0]          rd_word,
    output logic [WAYS-1:0][DATA_W-1:0] rd_ways,
    input  logic                        wr_en,
    input  logic [WAY_W-1:0]            wr_way,
    input  logic [WORD_SW-1:0]          wr_word,
    input  logic [DATA_W-1:0]           wr_data
);
    localparam int DEPTH = (1 << SET_BITS) * WORDS;

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_bank
            logic [DATA_W-1:0] words [DEPTH];

            always_ff @(posedge clk) begin
                if (wr_en && wr_way == WAY_W'(w)) words[{index, wr_word}] <= wr_data;
            end

            assign rd_ways[w] = words[{index, rd_word}];
        end
    endgenerate
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
    import cache_pkg::*;
#(
    parameter int SET_BITS = 5,
    parameter int TAG_W    = 22
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cpu_req,
    input  logic                        cpu_we,
    input  logic                        cpu_seq,
    input  logic [ADDR_W-1:0]           cpu_addr,
    input  logic [DATA_W-1:0]           cpu_wdata,
    input  logic                        cpu_cacheable,
    input  logic                        cpu_bufferable,
    input  logic                        cpu_writeback,
    input  logic [WAY_W-1:0]            victim_way,
    output logic                        cpu_ready,
    output logic [DATA_W-1:0]           cpu_rdata,
    output logic                        mem_req,
    output logic                        mem_we,
    output logic [ADDR_W-1:0]           mem_addr,
    output logic [DATA_W-1:0]           mem_wdata,
    input  logic [DATA_W-1:0]           mem_rdata,
    input  logic                        mem_ack,
    output logic                        wbuf_push,
    output logic [ADDR_W-1:0]           wbuf_addr,
    output logic [DATA_W-1:0]           wbuf_data,
    input  logic [WAYS-1:0]             hit_vec,
    output logic [WAY_W-1:0]            vic_sel,
    input  logic                        vic_valid,
    input  logic [1:0]                  vic_dirty,
    input  logic [TAG_W-1:0]            vic_tag,
    output logic [WORD_SW-1:0]          rd_word,
    input  logic [WAYS-1:0][DATA_W-1:0] rd_ways,
    output logic                        dw_en,
    output logic [WAY_W-1:0]            dw_way,
    output logic [WORD_SW-1:0]          dw_word,
    output logic [DATA_W-1:0]           dw_data,
    output logic                        alloc_en,
    output logic [WAY_W-1:0]            alloc_way,
    output logic                        dirty_en,
    output logic [WAY_W-1:0]            dirty_way,
    output logic                        dirty_half
);
    localparam int LINE_W = ADDR_W - OFF_W;

    cache_state_t          state_q, state_d;
    logic [WORD_SW-1:0]    cnt_q, cnt_d;
    logic [WAY_W-1:0]      vway_q;
    logic [LINE_W-1:0]     seq_line_q;
    logic [WAY_W-1:0]      seq_way_q;
    logic                  seq_ok_q;

    logic [SET_BITS-1:0]   idx;
    logic [WORD_SW-1:0]    word;
    logic [LINE_W-1:0]     line;
    logic                  use_seq;
    logic                  any_hit;
    logic [WAY_W-1:0]      enc_way;
    logic [WAY_W-1:0]      hit_way;
    logic                  lookup_act;

    assign idx     = cpu_addr[OFF_W +: SET_BITS];
    assign word    = cpu_addr[OFF_W-1:2];
    assign line    = cpu_addr[ADDR_W-1:OFF_W];
    assign use_seq = cpu_seq && seq_ok_q && (line == seq_line_q);
    assign any_hit = use_seq || (|hit_vec);
    assign hit_way = use_seq ? seq_way_q : enc_way;
    assign lookup_act = (state_q == ST_LOOKUP) && cpu_req;

    always_comb begin
        enc_way = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (hit_vec[i]) enc_way = WAY_W'(i);
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_LOOKUP: begin
                if (cpu_req && !any_hit) begin
                    if (cpu_we) begin
                        if (!cpu_bufferable) state_d = ST_SINGLE;
                    end else if (!cpu_cacheable) begin
                        state_d = ST_SINGLE;
                    end else if (vic_valid && (|vic_dirty)) begin
                        state_d = ST_EVICT;
                        cnt_d   = vic_dirty[0] ? 3'd0 : 3'd4;
                    end else begin
                        state_d = ST_FILL;
                        cnt_d   = 3'd0;
                    end
                end
            end
            ST_EVICT: begin
                if (mem_ack) begin
                    if (cnt_q == 3'd7 || (cnt_q == 3'd3 && !vic_dirty[1])) begin
                        state_d = ST_FILL;
                        cnt_d   = 3'd0;
                    end else begin
                        cnt_d = cnt_q + 3'd1;
                    end
                end
            end
            ST_FILL: begin
                if (mem_ack) begin
                    cnt_d = cnt_q + 3'd1;
                    if (cnt_q == 3'd7) state_d = ST_LOOKUP;
                end
            end
            ST_SINGLE: begin
                if (mem_ack) state_d = ST_LOOKUP;
            end
            default: state_d = ST_LOOKUP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_LOOKUP;
            cnt_q      <= '0;
            vway_q     <= '0;
            seq_line_q <= '0;
            seq_way_q  <= '0;
            seq_ok_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (lookup_act && any_hit) begin
                seq_line_q <= line;
                seq_way_q  <= hit_way;
                seq_ok_q   <= 1'b1;
            end
            if (state_q == ST_LOOKUP && (state_d == ST_EVICT || state_d == ST_FILL)) begin
                vway_q   <= victim_way;
                seq_ok_q <= 1'b0;
            end
        end
    end

    always_comb begin
        cpu_ready  = 1'b0;
        cpu_rdata  = rd_ways[hit_way];
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = cpu_addr;
        mem_wdata  = cpu_wdata;
        wbuf_push  = 1'b0;
        wbuf_addr  = cpu_addr;
        wbuf_data  = cpu_wdata;
        vic_sel    = (state_q == ST_LOOKUP) ? victim_way : vway_q;
        rd_word    = (state_q == ST_EVICT) ? cnt_q : word;
        dw_en      = 1'b0;
        dw_way     = hit_way;
        dw_word    = word;
        dw_data    = cpu_wdata;
        alloc_en   = 1'b0;
        alloc_way  = vway_q;
        dirty_en   = 1'b0;
        dirty_way  = hit_way;
        dirty_half = cpu_addr[OFF_W-1];
        unique case (state_q)
            ST_LOOKUP: begin
                if (cpu_req) begin
                    if (any_hit) begin
                        cpu_ready = 1'b1;
                        if (cpu_we) begin
                            dw_en = 1'b1;
                            if (cpu_writeback) dirty_en  = 1'b1;
                            else               wbuf_push = 1'b1;
                        end
                    end else if (cpu_we && cpu_bufferable) begin
                        cpu_ready = 1'b1;
                        wbuf_push = 1'b1;
                    end
                end
            end
            ST_EVICT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {vic_tag, idx, cnt_q, 2'b00};
                mem_wdata = rd_ways[vway_q];
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {line, cnt_q, 2'b00};
                if (mem_ack) begin
                    dw_en    = 1'b1;
                    dw_way   = vway_q;
                    dw_word  = cnt_q;
                    dw_data  = mem_rdata;
                    alloc_en = (cnt_q == 3'd7);
                end
            end
            ST_SINGLE: begin
                mem_req = 1'b1;
                mem_we  = cpu_we;
                if (mem_ack) begin
                    cpu_ready = 1'b1;
                    cpu_rdata = mem_rdata;
                end
            end
            default: ;
        endcase
    end

    assert_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL || state_q == ST_EVICT) |-> !cpu_ready);

    assert_fill_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && mem_ack && cnt_q != 3'd7)
        |=> (state_q == ST_FILL && mem_addr[4:2] == $past(mem_addr[4:2]) + 3'd1));

    assert_fill_hits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && mem_ack && cnt_q == 3'd7 && cpu_req)
        |=> (state_q == ST_LOOKUP && hit_vec[$past(vway_q)]));

    assert_dirty_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dirty_en |-> (cpu_writeback && cpu_we && state_q == ST_LOOKUP));

    assert_wbuf_push_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wbuf_push |-> (cpu_we && cpu_ready && state_q == ST_LOOKUP));

    assert_evict_dirty_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVICT) |-> (vic_valid && vic_dirty[cnt_q[2]] && mem_we));

    assert_seq_way_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup_act && use_seq) |-> hit_vec[seq_way_q]);
endmodule

// File: rtl/four_way_cache.sv
module four_way_cache
    import cache_pkg::*;
#(
    parameter int SET_BITS = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpu_req,
    input  logic        cpu_we,
    input  logic        cpu_seq,
    input  logic [31:0] cpu_addr,
    input  logic [31:0] cpu_wdata,
    input  logic        cpu_cacheable,
    input  logic        cpu_bufferable,
    input  logic        cpu_writeback,
    input  logic [1:0]  victim_way,
    output logic        cpu_ready,
    output logic [31:0] cpu_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ack,
    output logic        wbuf_push,
    output logic [31:0] wbuf_addr,
    output logic [31:0] wbuf_data
);
    localparam int TAG_W = ADDR_W - OFF_W - SET_BITS;

    logic [WAYS-1:0]             hit_vec;
    logic [WAY_W-1:0]            vic_sel;
    logic                        vic_valid;
    logic [1:0]                  vic_dirty;
    logic [TAG_W-1:0]            vic_tag;
    logic [WORD_SW-1:0]          rd_word;
    logic [WAYS-1:0][DATA_W-1:0] rd_ways;
    logic                        dw_en;
    logic [WAY_W-1:0]            dw_way;
    logic [WORD_SW-1:0]          dw_word;
    logic [DATA_W-1:0]           dw_data;
    logic                        alloc_en;
    logic [WAY_W-1:0]            alloc_way;
    logic                        dirty_en;
    logic [WAY_W-1:0]            dirty_way;
    logic                        dirty_half;

    cache_tag_store #(.SET_BITS(SET_BITS), .TAG_W(TAG_W)) i_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .index      (cpu_addr[OFF_W +: SET_BITS]),
        .lk_tag     (cpu_addr[ADDR_W-1 -: TAG_W]),
        .hit_vec    (hit_vec),
        .vic_sel    (vic_sel),
        .vic_valid  (vic_valid),
        .vic_dirty  (vic_dirty),
        .vic_tag    (vic_tag),
        .alloc_en   (alloc_en),
        .alloc_way  (alloc_way),
        .dirty_en   (dirty_en),
        .dirty_way  (dirty_way),
        .dirty_half (dirty_half)
    );

    cache_data_store #(.SET_BITS(SET_BITS)) i_data (
        .clk     (clk),
        .index   (cpu_addr[OFF_W +: SET_BITS]),
        .rd_word (rd_word),
        .rd_ways (rd_ways),
        .wr_en   (dw_en),
        .wr_way  (dw_way),
        .wr_word (dw_word),
        .wr_data (dw_data)
    );

    cache_ctrl #(.SET_BITS(SET_BITS), .TAG_W(TAG_W)) i_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .cpu_req        (cpu_req),
        .cpu_we         (cpu_we),
        .cpu_seq        (cpu_seq),
        .cpu_addr       (cpu_addr),
        .cpu_wdata      (cpu_wdata),
        .cpu_cacheable  (cpu_cacheable),
        .cpu_bufferable (cpu_bufferable),
        .cpu_writeback  (cpu_writeback),
        .victim_way     (victim_way),
        .cpu_ready      (cpu_ready),
        .cpu_rdata      (cpu_rdata),
        .mem_req        (mem_req),
        .mem_we         (mem_we),
        .mem_addr       (mem_addr),
        .mem_wdata      (mem_wdata),
        .mem_rdata      (mem_rdata),
        .mem_ack        (mem_ack),
        .wbuf_push      (wbuf_push),
        .wbuf_addr      (wbuf_addr),
        .wbuf_data      (wbuf_data),
        .hit_vec        (hit_vec),
        .vic_sel        (vic_sel),
        .vic_valid      (vic_valid),
        .vic_dirty      (vic_dirty),
        .vic_tag        (vic_tag),
        .rd_word        (rd_word),
        .rd_ways        (rd_ways),
        .dw_en          (dw_en),
        .dw_way         (dw_way),
        .dw_word        (dw_word),
        .dw_data        (dw_data),
        .alloc_en       (alloc_en),
        .alloc_way      (alloc_way),
        .dirty_en       (dirty_en),
        .dirty_way      (dirty_way),
        .dirty_half     (dirty_half)
    );
endmodule

// File: tb/test_four_way_cache.sv
module test_four_way_cache;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0, cpu_seq = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic        cpu_cacheable = 1'b1, cpu_bufferable = 1'b1, cpu_writeback = 1'b1;
    logic [1:0]  victim_way = '0;
    logic        cpu_ready, mem_req, mem_we, wbuf_push;
    logic [31:0] cpu_rdata, mem_addr, mem_wdata, wbuf_addr, wbuf_data;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    int n_checks = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    four_way_cache i_four_way_cache (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_seq(cpu_seq),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_cacheable(cpu_cacheable),
        .cpu_bufferable(cpu_bufferable), .cpu_writeback(cpu_writeback),
        .victim_way(victim_way), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .wbuf_push(wbuf_push),
        .wbuf_addr(wbuf_addr), .wbuf_data(wbuf_data)
    );

    // external memory model with beat log
    logic [31:0] store [logic [31:0]];
    logic        log_we   [256];
    logic [31:0] log_addr [256];
    logic [31:0] log_data [256];
    int          log_n = 0;

    function automatic logic [31:0] pat(input logic [31:0] a);
        return a ^ 32'hC0DE_0000;
    endfunction

    function automatic logic [31:0] mem_read(input logic [31:0] a);
        if (store.exists(a)) return store[a];
        return pat(a);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else begin
            if (mem_req && mem_ack && log_n < 256) begin
                log_we[log_n]   = mem_we;
                log_addr[log_n] = mem_addr;
                log_data[log_n] = mem_we ? mem_wdata : mem_rdata;
                if (mem_we) store[mem_addr] = mem_wdata;
                log_n = log_n + 1;
            end
            mem_ack   <= mem_req && !mem_ack;
            mem_rdata <= mem_read(mem_addr);
        end
    end

    // results of the last access
    logic [31:0] r_data, r_paddr, r_pdata;
    logic        r_push;
    int          r_cyc;
    int          r_beats;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [31:0] addr, input logic [31:0] wd,
                          input logic seq, input logic cach, input logic buff,
                          input logic wb, input logic [1:0] vic);
        int base;
        base = log_n;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd; cpu_seq = seq;
        cpu_cacheable = cach; cpu_bufferable = buff; cpu_writeback = wb; victim_way = vic;
        r_cyc = 0; r_push = 1'b0;
        forever begin
            #1;
            if (cpu_ready) begin
                r_data = cpu_rdata; r_push = wbuf_push; r_paddr = wbuf_addr; r_pdata = wbuf_data;
                break;
            end
            @(negedge clk);
            r_cyc++;
            if (r_cyc > 500) break;
        end
        @(posedge clk);
        #1 cpu_req = 1'b0; cpu_seq = 1'b0;
        r_beats = log_n - base;
    endtask

    task automatic rd(input logic [31:0] a, input logic [1:0] vic);
        access(1'b0, a, 32'h0, 1'b0, 1'b1, 1'b1, 1'b1, vic);
    endtask

    task automatic check_fill(input string req, input logic [31:0] a, input int first);
        for (int k = 0; k < 8; k++) begin
            check({req, " fill addr"}, log_addr[first+k], {a[31:5], 5'b0} + 32'(4*k));
            check({req, " fill rd"}, 32'(log_we[first+k]), 32'h0);
        end
    endtask

    localparam logic [31:0] LA = 32'h0000_1040, LB = 32'h0000_1440, LC = 32'h0000_1840;
    localparam logic [31:0] LD = 32'h0000_1C40, LE = 32'h0000_2040;

    task automatic t_reset_and_fill();
        check("R3 ready idle", 32'(cpu_ready), 0);
        check("R3 mem idle", 32'(mem_req), 0);
        check("R3 push idle", 32'(wbuf_push), 0);
        rd(LA + 8, 2'd1);
        check("R3 miss after reset beats", r_beats, 8);
        check_fill("R4", LA, log_n - 8);
        check("R4 data", r_data, pat(LA + 8));
        check("R4 stall", 32'(r_cyc >= 16), 1);
    endtask

    task automatic t_hit();
        rd(LA + 32'h1C, 2'd0);
        check("R2 hit cycles", r_cyc, 0);
        check("R2 hit data", r_data, pat(LA + 32'h1C));
        check("R2 hit beats", r_beats, 0);
    endtask

    task automatic t_seq();
        rd(LA, 2'd0);
        for (int k = 1; k < 4; k++) begin
            access(1'b0, LA + 32'(4*k), 32'h0, 1'b1, 1'b1, 1'b1, 1'b1, 2'd0);
            check("R12 seq cycles", r_cyc, 0);
            check("R12 seq data", r_data, pat(LA + 32'(4*k)));
        end
    endtask

    task automatic t_coexist();
        rd(LB, 2'd2);
        check("R1 other tag fills", r_beats, 8);
        rd(LA + 4, 2'd0);
        check("R1 first line kept", r_beats, 0);
        check("R1 first line data", r_data, pat(LA + 4));
        rd(LB + 4, 2'd0);
        check("R1 second line hit", r_beats, 0);
    endtask

    task automatic t_replace();
        rd(LC, 2'd1);
        check("R5 clean victim beats", r_beats, 8);
        rd(LA, 2'd3);
        check("R5 replaced line misses", r_beats, 8);
        rd(LB, 2'd0);
        check("R5 other way untouched", r_beats, 0);
    endtask

    task automatic t_dirty_upper();
        access(1'b1, LA + 32'h14, 32'h1111_2222, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0);
        check("R6 write hit cycles", r_cyc, 0);
        check("R6 write hit beats", r_beats, 0);
        check("R7 wb no push", 32'(r_push), 0);
        rd(LA + 32'h14, 2'd0);
        check("R6 readback", r_data, 32'h1111_2222);
        rd(LD, 2'd3);
        check("R11 upper half only", r_beats, 12);
        for (int k = 0; k < 4; k++) begin
            check("R11 wb addr", log_addr[log_n-12+k], LA + 32'h10 + 32'(4*k));
            check("R11 wb is write", 32'(log_we[log_n-12+k]), 1);
        end
        check("R11 wb data new", log_data[log_n-11], 32'h1111_2222);
        check("R11 wb data old", log_data[log_n-12], pat(LA + 32'h10));
        check_fill("R11", LD, log_n - 8);
        check("R4 new line data", r_data, pat(LD));
    endtask

    task automatic t_write_through();
        access(1'b1, LB, 32'h0000_3333, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0);
        check("R7 wt push", 32'(r_push), 1);
        check("R7 wt push addr", r_paddr, LB);
        check("R7 wt push data", r_pdata, 32'h0000_3333);
        rd(LB, 2'd0);
        check("R6 wt readback", r_data, 32'h0000_3333);
        rd(LE, 2'd2);
        check("R7 wt line stays clean", r_beats, 8);
        check("R7 wt no write beat", 32'(log_we[log_n-8]), 0);
    endtask

    task automatic t_buffered_miss();
        access(1'b1, 32'h3000, 32'h0000_4444, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0);
        check("R8 push", 32'(r_push), 1);
        check("R8 push addr", r_paddr, 32'h3000);
        check("R8 cycles", r_cyc, 0);
        check("R8 beats", r_beats, 0);
        rd(32'h3000, 2'd0);
        check("R8 not allocated", r_beats, 8);
        check("R8 data from memory", r_data, pat(32'h3000));
    endtask

    task automatic t_both_halves();
        access(1'b1, 32'h3004, 32'hAAAA_0001, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0);
        access(1'b1, 32'h3018, 32'hAAAA_0006, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0);
        rd(32'h3400, 2'd0);
        check("R11 both halves beats", r_beats, 16);
        for (int k = 0; k < 8; k++) begin
            check("R11 full wb addr", log_addr[log_n-16+k], 32'h3000 + 32'(4*k));
        end
        check("R11 wb word1", log_data[log_n-15], 32'hAAAA_0001);
        check("R11 wb word6", log_data[log_n-10], 32'hAAAA_0006);
        check_fill("R11", 32'h3400, log_n - 8);
    endtask

    task automatic t_unbuffered_miss();
        access(1'b1, 32'h4000, 32'h0000_5555, 1'b0, 1'b1, 1'b0, 1'b1, 2'd1);
        check("R9 one beat", r_beats, 1);
        check("R9 is write", 32'(log_we[log_n-1]), 1);
        check("R9 addr", log_addr[log_n-1], 32'h4000);
        check("R9 no push", 32'(r_push), 0);
        rd(32'h4000, 2'd1);
        check("R9 not allocated", r_beats, 8);
        check("R9 memory updated", r_data, 32'h0000_5555);
    endtask

    task automatic t_uncached();
        for (int k = 0; k < 2; k++) begin
            access(1'b0, 32'h5008, 32'h0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0);
            check("R10 one beat", r_beats, 1);
            check("R10 read beat", 32'(log_we[log_n-1]), 0);
            check("R10 data", r_data, pat(32'h5008));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset_and_fill();
        t_hit();
        t_seq();
        t_coexist();
        t_replace();
        t_dirty_upper();
        t_write_through();
        t_buffered_miss();
        t_both_halves();
        t_unbuffered_miss();
        t_uncached();
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        n_checks++;
        n_bad++;
        $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule